// File: doc/BRIEF.md
# Fast Fault Shutdown Controller

This block supervises one shared, active-low shutdown line that also carries an open-drain pulldown. It reads a digitized overcurrent trip signal and two threshold flags. One flag says the line is below its lower switching threshold. The other says the line is above its upper threshold. A set of high-side and low-side gate commands, one pair per phase, passes through to the gate outputs only while the block allows it.

When a trip arrives, every gate output is forced off in the same cycle through a combinational path. The block then turns on the pulldown and holds it until the line is seen below the lower threshold. The pulldown is then released, and the external RC network charges the line back up. The gates stay off until the line is seen above the upper threshold. The release point and the re-enable point are two different thresholds, so the real disable time is longer than the RC time constant alone. An external controller that pulls the line low also turns the gates off, without raising the fault indication.

The state machine has three states. IDLE means normal operation with the pulldown off. FAULT_PULL means the pulldown is on. RECOVER means the pulldown is off and the block is waiting for the upper threshold. The transitions are:
- IDLE to FAULT_PULL on a trip.
- FAULT_PULL to RECOVER on the synchronized lower flag.
- RECOVER to FAULT_PULL on a trip, which has priority.
- RECOVER to IDLE on the synchronized upper flag.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the state is IDLE, the pulldown is off and the fault indication is low. All gate outputs stay off until the line has been seen above the upper threshold.
- R2: When the trip input is high, every gate output is 0 and the disable output is 1 in that same cycle, with no clock edge in between.
- R3: A trip sampled at a clock edge while in IDLE makes the pulldown and the fault indication go high from that edge onward.
- R4: The pulldown stays on until the clock edge at which the synchronized lower-threshold flag is 1. At that edge the block enters RECOVER and releases the pulldown.
- R5: In RECOVER the pulldown is off and all gate outputs remain off. The synchronized upper-threshold flag at an edge returns the block to IDLE.
- R6: A trip sampled in RECOVER returns the block to FAULT_PULL. This holds even when the synchronized upper flag is also 1 at that edge: the trip wins.
- R7: While no trip is present, a lower-threshold indication on the line disables all gates, with the pulldown and the fault indication both low. The gates come back after the upper-threshold indication.
- R8: Each threshold flag passes through SYNC_STAGES flip-flops (default 2) before any decision uses it. A flag that is 1 at edge n therefore takes effect at edge n+2.
- R9: While enabled, each gate output equals its own command bit, phase by phase. Bit i of the high-side and low-side buses belongs to phase i.
- R10: The fault indication is high in FAULT_PULL and RECOVER, and low only in IDLE.
- R11: The line level uses hysteresis. A synchronized lower flag clears the level and a synchronized upper flag sets it. If both flags are 1 at once, the lower flag wins and the level is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_trip | input | 1 | Digitized overcurrent trip, synchronous to clk |
| line_lo_flag | input | 1 | Shared line is below the lower threshold (asynchronous) |
| line_hi_flag | input | 1 | Shared line is above the upper threshold (asynchronous) |
| hs_cmd | input | PHASES | High-side gate commands, bit i is phase i |
| ls_cmd | input | PHASES | Low-side gate commands, bit i is phase i |
| hs_gate | output | PHASES | High-side gate outputs |
| ls_gate | output | PHASES | Low-side gate outputs |
| od_pull | output | 1 | Pulldown enable for the shared line |
| fault_active | output | 1 | Fault sequence in progress (not IDLE) |
| outputs_off | output | 1 | All gates currently disabled |

## Verification
The sharpest collision is a new trip arriving in exactly the cycle at which the synchronized upper flag would end RECOVER. The bench provokes it by raising the upper flag and then raising the trip two cycles later, so both reach the state machine at the same edge. The expected result is FAULT_PULL with the pulldown on. A second overlap, both threshold flags high together, is judged against the lower flag taking priority. A cycle-by-cycle behavioural model predicts every output on every clock and is compared with the design throughout.

// File: rtl/ffsd_pkg.sv
package ffsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_FAULT_PULL = 2'd1,
        ST_RECOVER    = 2'd2
    } sd_state_e;

endpackage

// File: rtl/ffsd_sync.sv
module ffsd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r <= '0;
                else        r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ffsd_line_hyst.sv
module ffsd_line_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo,
    input  logic above_hi,
    output logic line_high
);
    // Lower flag has priority; level starts low so gates stay off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line_high <= 1'b0;
        else if (below_lo) line_high <= 1'b0;
        else if (above_hi) line_high <= 1'b1;
    end
endmodule

// File: rtl/ffsd_fsm.sv
module ffsd_fsm
    import ffsd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic below_lo,
    input  logic above_hi,
    output logic pull_en,
    output logic in_fault
);
    sd_state_e state_q;
    sd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trip) state_d = ST_FAULT_PULL;
            end
            ST_FAULT_PULL: begin
                if (below_lo) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (trip)          state_d = ST_FAULT_PULL;
                else if (above_hi) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pull_en  = 1'b0;
        in_fault = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pull_en  = 1'b0;
                in_fault = 1'b0;
            end
            ST_FAULT_PULL: begin
                pull_en  = 1'b1;
                in_fault = 1'b1;
            end
            ST_RECOVER: begin
                pull_en  = 1'b0;
                in_fault = 1'b1;
            end
            default: begin
                pull_en  = 1'b0;
                in_fault = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ffsd_gate_mask.sv
module ffsd_gate_mask #(
    parameter int PHASES = 3
) (
    input  logic              kill,
    input  logic [PHASES-1:0] hs_cmd,
    input  logic [PHASES-1:0] ls_cmd,
    output logic [PHASES-1:0] hs_gate,
    output logic [PHASES-1:0] ls_gate
);
    generate
        for (genvar p = 0; p < PHASES; p++) begin : g_phase
            assign hs_gate[p] = hs_cmd[p] & ~kill;
            assign ls_gate[p] = ls_cmd[p] & ~kill;
        end
    endgenerate
endmodule

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl #(
    parameter int PHASES      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oc_trip,
    input  logic              line_lo_flag,
    input  logic              line_hi_flag,
    input  logic [PHASES-1:0] hs_cmd,
    input  logic [PHASES-1:0] ls_cmd,
    output logic [PHASES-1:0] hs_gate,
    output logic [PHASES-1:0] ls_gate,
    output logic              od_pull,
    output logic              fault_active,
    output logic              outputs_off
);
    logic lo_s;
    logic hi_s;
    logic line_high;

    ffsd_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .d(line_lo_flag), .q(lo_s)
    );
    ffsd_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
        .clk(clk), .rst_n(rst_n), .d(line_hi_flag), .q(hi_s)
    );

    ffsd_line_hyst u_hyst (
        .clk(clk), .rst_n(rst_n), .below_lo(lo_s), .above_hi(hi_s),
        .line_high(line_high)
    );

    ffsd_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .trip(oc_trip), .below_lo(lo_s),
        .above_hi(hi_s), .pull_en(od_pull), .in_fault(fault_active)
    );

    // Raw trip joins the registered state directly: no added latency
    assign outputs_off = oc_trip | fault_active | ~line_high;

    ffsd_gate_mask #(.PHASES(PHASES)) u_mask (
        .kill(outputs_off), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );
endmodule

// File: rtl/ffsd_chk.sv
module ffsd_chk #(
    parameter int PHASES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              oc_trip,
    input logic [PHASES-1:0] hs_gate,
    input logic [PHASES-1:0] ls_gate,
    input logic              od_pull,
    input logic              fault_active,
    input logic              outputs_off
);
    // R2
    trip_kills_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_trip |-> (hs_gate == '0 && ls_gate == '0 && outputs_off));

    // R3
    pull_needs_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(od_pull) |-> $past(oc_trip));

    // R10
    pull_implies_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_pull |-> fault_active);

    // R4
    release_into_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(od_pull) |-> fault_active);

    // R5
    fault_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_active |-> (hs_gate == '0 && ls_gate == '0));

    // R6
    recover_retrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_active && !od_pull && oc_trip) |=> od_pull);
endmodule

bind fault_shutdown_ctrl ffsd_chk #(.PHASES(PHASES)) chk_i (
    .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip), .hs_gate(hs_gate),
    .ls_gate(ls_gate), .od_pull(od_pull), .fault_active(fault_active),
    .outputs_off(outputs_off)
);

// File: tb/fault_shutdown_ctrl_tb_top.sv
module fault_shutdown_ctrl_tb_top;
    localparam int PH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_trip = 1'b0, line_lo_flag = 1'b0, line_hi_flag = 1'b0;
    logic [PH-1:0] hs_cmd = '0, ls_cmd = '0;
    logic [PH-1:0] hs_gate, ls_gate;
    logic od_pull, fault_active, outputs_off;

    int n_run = 0;
    int n_fail = 0;

    // model state: 0 idle, 1 pulling, 2 recovering
    int m_state = 0;
    bit m_level = 0;
    bit lo_q[$];
    bit hi_q[$];

    always #4 clk = ~clk;

    fault_shutdown_ctrl #(.PHASES(PH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip),
        .line_lo_flag(line_lo_flag), .line_hi_flag(line_hi_flag),
        .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .hs_gate(hs_gate),
        .ls_gate(ls_gate), .od_pull(od_pull),
        .fault_active(fault_active), .outputs_off(outputs_off)
    );

    task automatic model_reset();
        m_state = 0;
        m_level = 0;
        lo_q = {0, 0};
        hi_q = {0, 0};
    endtask

    task automatic step(input bit rst, input bit oc, input bit lo, input bit hi,
                        input logic [PH-1:0] hs, input logic [PH-1:0] ls,
                        input string tag);
        bit dis;
        logic [2*PH+2:0] exp_v, act_v;
        bit lo_d, hi_d;
        @(negedge clk);
        rst_n = rst; oc_trip = oc; line_lo_flag = lo; line_hi_flag = hi;
        hs_cmd = hs; ls_cmd = ls;
        #2;
        dis = oc || (m_state != 0) || !m_level;
        exp_v = {dis ? '0 : hs, dis ? '0 : ls, m_state == 1, m_state != 0, dis};
        act_v = {hs_gate, ls_gate, od_pull, fault_active, outputs_off};
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (hs,ls,pull,fault,off) at %0t",
                     tag, act_v, exp_v, $time);
        end
        @(posedge clk);
        if (!rst) model_reset();
        else begin
            lo_d = lo_q.pop_front();
            hi_d = hi_q.pop_front();
            lo_q.push_back(lo);
            hi_q.push_back(hi);
            case (m_state)
                0: if (oc) m_state = 1;
                1: if (lo_d) m_state = 2;
                2: if (oc) m_state = 1; else if (hi_d) m_state = 0;
                default: m_state = 0;
            endcase
            if (lo_d) m_level = 0;
            else if (hi_d) m_level = 1;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 3'b111, 3'b111, "R1 in reset");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 3'b101, 3'b010, "R1 after reset");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 3'b101, 3'b010, "R8 upper latency");
        step(1, 0, 0, 1, 3'b001, 3'b110, "R9 pattern a");
        step(1, 0, 0, 1, 3'b110, 3'b001, "R9 pattern b");
        step(1, 0, 0, 1, 3'b011, 3'b100, "R9 pattern c");
        // trip while enabled
        step(1, 1, 0, 1, 3'b111, 3'b000, "R2 same-cycle kill");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 3'b111, 3'b111, "R3 R10 pull held");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 3'b111, 3'b111, "R4 release");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 3'b111, 3'b111, "R5 recover off");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 3'b101, 3'b010, "R5 re-enable");
        // trip again, reach recover, retrip
        step(1, 1, 0, 1, 3'b101, 3'b010, "R2 second trip");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 3'b101, 3'b010, "R4 drop");
        step(1, 0, 0, 0, 3'b101, 3'b010, "R10 recover");
        step(1, 1, 0, 0, 3'b101, 3'b010, "R6 retrip in recover");
        for (int i = 0; i < 2; i++) step(1, 0, 0, 0, 3'b101, 3'b010, "R6 pulling again");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 3'b101, 3'b010, "R4 drop again");
        step(1, 0, 0, 0, 3'b101, 3'b010, "R5 recover");
        // collision: upper flag reaches the FSM in the same edge as a trip
        step(1, 0, 0, 1, 3'b101, 3'b010, "R6 collision prep");
        step(1, 0, 0, 1, 3'b101, 3'b010, "R6 collision prep");
        step(1, 1, 0, 1, 3'b101, 3'b010, "R6 collision trip wins");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 3'b101, 3'b010, "R6 after collision");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 3'b101, 3'b010, "R4 final drop");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 3'b110, 3'b001, "R5 back to idle");
        // external controller pulls the line low
        for (int i = 0; i < 5; i++) step(1, 0, 1, 0, 3'b110, 3'b001, "R7 external low");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 3'b110, 3'b001, "R7 external release");
        // both flags at once
        for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 3'b111, 3'b111, "R11 both flags");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 3'b111, 3'b111, "R11 recovery");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule